// File: doc/BRIEF.md
# Processor-Attached Serial Byte Transmitter

This block sends bytes from a small processor out over one asynchronous serial line. The processor puts a byte on a data bus and pulses a write strobe for one system clock. The block holds the byte and adds a start bit, an optional parity bit and a stop bit. It then shifts the frame out least-significant data bit first, one bit per period of a slow bit clock. The line is TTL level and idles high.

The bit clock is a separate clock domain. A divider running on the system clock makes it, and by default it turns 12 MHz into 1200 Hz, toggling every 5000 input cycles. The write logic and the shifter therefore run on different clocks. A four-phase request/acknowledge handshake carries each byte across, with two-flop synchronizers in each direction.

A busy flag tells the processor when it may write again. A write made while busy is dropped. Reset is synchronous and active high. The transmit domain also holds its reset for two bit-clock periods after the divider restarts.

Top module: `uartx_top`

## Requirements
- R1: After reset is released and two bit-clock periods have passed, `txd` is high and `busy` is low. While no frame is in progress `txd` stays high.
- R2: A frame is one low start bit, then the data bits least-significant first, then any parity bit, then one high stop bit. Each bit is held for one bit-clock period, which is 2*(SYS_HZ/(2*BAUD)) system clock cycles.
- R3: Writing 0x41 with `par_mode` = 2'b00 produces low, then 1,0,0,0,0,0,1,0, then high.
- R4: `par_mode` is sampled with the write. 2'b00 and 2'b11 send no parity bit. 2'b01 sends even parity, equal to the XOR of the data bits. 2'b10 sends odd parity, the inverse of that XOR. The parity bit sits between the last data bit and the stop bit.
- R5: `busy` is high on the system clock cycle after an accepted write. It stays high through the whole stop bit and falls within 8 system cycles after the stop bit ends.
- R6: A write strobe while `busy` is high has no effect: the byte in flight is unchanged and no extra frame is sent.
- R7: The request is held until the acknowledge is seen, and the acknowledge is held until the request is seen to drop. Frames written back to back as soon as `busy` falls are each sent intact.
- R8: The bit clock toggles every SYS_HZ/(2*BAUD) system cycles. For a byte whose bit 0 is 1, the start bit lasts exactly 2*SYS_HZ/(2*BAUD) system cycles.
- R9: Reset asserted in the middle of a frame returns `txd` to high and `busy` to low within a few bit periods. The next write is then sent correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (12 MHz by default) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe from the processor |
| wr_data | input | DW | Byte to send |
| par_mode | input | 2 | Parity selection, sampled on write |
| busy | output | 1 | High from an accepted write until the frame has ended |
| txd | output | 1 | Serial output line, idles high |

## Verification
`busy` is due on the first system cycle after the write edge, and the bench samples it on the falling edge that follows. The start bit comes after the request passes through the bit-domain synchronizer, so it appears one to three bit periods after the write. The bench therefore waits for the line to fall, then samples each bit half a bit period in, at multiples of the bit length. `busy` must still be high at the middle of the stop bit and low within eight system cycles after the stop bit ends. The bench allows half a bit plus that margin before it checks. The start bit's length is measured exactly in system cycles, because both of its edges fall on bit-clock edges.

// File: rtl/uartx_pkg.sv
package uartx_pkg;
    typedef enum logic [1:0] {
        PAR_OFF   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_ODD   = 2'b10,
        PAR_OFF_B = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_REQ   = 2'd1,
        HS_DROP  = 2'd2,
        HS_DRAIN = 2'd3
    } hs_state_e;
endpackage

// File: rtl/uartx_div.sv
module uartx_div #(
    parameter int HALF = 5000
) (
    input  logic clk,
    input  logic rst,
    output logic bclk,
    output logic tx_rst
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          bclk;
        logic          trst;
        logic          fall1;
    } div_t;

    div_t q, d;

    always_comb begin
        d = q;
        if (q.cnt == CW'(HALF - 1)) begin
            d.cnt  = '0;
            d.bclk = ~q.bclk;
            // reset of the bit domain is released on a falling edge only
            if (q.bclk && q.trst) begin
                if (q.fall1) d.trst  = 1'b0;
                else         d.fall1 = 1'b1;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.cnt   <= '0;
            q.bclk  <= 1'b0;
            q.trst  <= 1'b1;
            q.fall1 <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign bclk   = q.bclk;
    assign tx_rst = q.trst;
endmodule

// File: rtl/uartx_host.sv
module uartx_host
    import uartx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    par_mode,
    input  logic          ack_tx,
    input  logic          act_tx,
    output logic          req,
    output logic [DW-1:0] hold_data,
    output logic          hold_par,
    output logic          hold_pen,
    output logic          busy
);
    typedef struct packed {
        hs_state_e     state;
        logic          ack_m;
        logic          ack_s;
        logic          act_m;
        logic          act_s;
        logic [DW-1:0] data;
        logic          par;
        logic          pen;
    } host_t;

    host_t q, d;
    par_mode_e mode;

    assign mode = par_mode_e'(par_mode);

    always_comb begin
        d       = q;
        d.ack_m = ack_tx;
        d.ack_s = q.ack_m;
        d.act_m = act_tx;
        d.act_s = q.act_m;
        case (q.state)
            HS_IDLE: begin
                if (wr_en) begin
                    d.data  = wr_data;
                    d.pen   = (mode == PAR_EVEN) || (mode == PAR_ODD);
                    d.par   = (mode == PAR_ODD) ? ~(^wr_data) : (^wr_data);
                    d.state = HS_REQ;
                end
            end
            HS_REQ:   if (q.ack_s)  d.state = HS_DROP;
            HS_DROP:  if (!q.ack_s) d.state = HS_DRAIN;
            HS_DRAIN: if (!q.act_s) d.state = HS_IDLE;
            default:  d.state = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state <= HS_IDLE;
            q.ack_m <= 1'b0;
            q.ack_s <= 1'b0;
            q.act_m <= 1'b0;
            q.act_s <= 1'b0;
            q.data  <= '0;
            q.par   <= 1'b0;
            q.pen   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign req       = (q.state == HS_REQ);
    assign busy      = (q.state != HS_IDLE);
    assign hold_data = q.data;
    assign hold_par  = q.par;
    assign hold_pen  = q.pen;
endmodule

// File: rtl/uartx_shift.sv
module uartx_shift #(
    parameter int DW = 8
) (
    input  logic          bclk,
    input  logic          tx_rst,
    input  logic          req_in,
    input  logic [DW-1:0] data,
    input  logic          par,
    input  logic          pen,
    output logic          ack,
    output logic          active,
    output logic          txd
);
    localparam int FW = DW + 2;
    localparam int CW = $clog2(FW + 1);

    typedef struct packed {
        logic          req_m;
        logic          req_s;
        logic          ack;
        logic          active;
        logic          line;
        logic [FW-1:0] shreg;
        logic [CW-1:0] cnt;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d       = q;
        d.req_m = req_in;
        d.req_s = q.req_m;
        if (q.ack && !q.req_s) d.ack = 1'b0;
        if (!q.active) begin
            if (q.req_s && !q.ack) begin
                d.ack    = 1'b1;
                d.active = 1'b1;
                d.line   = 1'b0;
                d.shreg  = {1'b1, (pen ? par : 1'b1), data};
                d.cnt    = pen ? CW'(DW + 2) : CW'(DW + 1);
            end
        end else if (q.cnt != '0) begin
            d.line  = q.shreg[0];
            d.shreg = q.shreg >> 1;
            d.cnt   = q.cnt - 1'b1;
        end else begin
            d.active = 1'b0;
        end
    end

    always_ff @(posedge bclk) begin
        if (tx_rst) begin
            q.req_m  <= 1'b0;
            q.req_s  <= 1'b0;
            q.ack    <= 1'b0;
            q.active <= 1'b0;
            q.line   <= 1'b1;
            q.shreg  <= '1;
            q.cnt    <= '0;
        end else begin
            q <= d;
        end
    end

    assign ack    = q.ack;
    assign active = q.active;
    assign txd    = q.line;
endmodule

// File: rtl/uartx_top.sv
module uartx_top #(
    parameter int SYS_HZ = 12_000_000,
    parameter int BAUD   = 1200,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    par_mode,
    output logic          busy,
    output logic          txd
);
    localparam int DIV_HALF = SYS_HZ / (2 * BAUD);

    logic          bclk_w;
    logic          tx_rst_w;
    logic          req_w;
    logic          ack_w;
    logic          act_w;
    logic [DW-1:0] hold_data_w;
    logic          hold_par_w;
    logic          hold_pen_w;

    uartx_div #(.HALF(DIV_HALF)) u_div (
        .clk    (clk),
        .rst    (rst),
        .bclk   (bclk_w),
        .tx_rst (tx_rst_w)
    );

    uartx_host #(.DW(DW)) u_host (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .par_mode  (par_mode),
        .ack_tx    (ack_w),
        .act_tx    (act_w),
        .req       (req_w),
        .hold_data (hold_data_w),
        .hold_par  (hold_par_w),
        .hold_pen  (hold_pen_w),
        .busy      (busy)
    );

    uartx_shift #(.DW(DW)) u_shift (
        .bclk   (bclk_w),
        .tx_rst (tx_rst_w),
        .req_in (req_w),
        .data   (hold_data_w),
        .par    (hold_par_w),
        .pen    (hold_pen_w),
        .ack    (ack_w),
        .active (act_w),
        .txd    (txd)
    );
endmodule

// File: rtl/uartx_chk.sv
module uartx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          busy,
    input logic          txd,
    input logic          bclk,
    input logic          tx_rst,
    input logic          req,
    input logic          ack,
    input logic          act,
    input logic [DW-1:0] hold_data
);
    // R5
    busy_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy) |=> busy);

    // R6
    write_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> $stable(hold_data));

    // R9
    reset_busy_chk: assert property (@(posedge clk)
        rst |=> !busy);

    // R1
    idle_line_chk: assert property (@(posedge bclk) disable iff (tx_rst)
        !act |-> txd);

    // R2
    start_bit_chk: assert property (@(posedge bclk) disable iff (tx_rst)
        $rose(ack) |-> (!txd && act));

    // R7
    ack_hold_chk: assert property (@(posedge bclk) disable iff (tx_rst || rst)
        (ack && req) |=> ack);
endmodule

bind uartx_top uartx_chk #(.DW(DW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .busy      (busy),
    .txd       (txd),
    .bclk      (bclk_w),
    .tx_rst    (tx_rst_w),
    .req       (req_w),
    .ack       (ack_w),
    .act       (act_w),
    .hold_data (hold_data_w)
);

// File: tb/uartx_top_tb_top.sv
`timescale 1ns/1ps
module uartx_top_tb_top;
    localparam int HALF = 3;
    localparam int BITC = 2 * HALF;
    localparam int BAUD = 1200;
    localparam int SYS  = BAUD * 2 * HALF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] par_mode = 2'b00;
    logic       busy;
    logic       txd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uartx_top #(.SYS_HZ(SYS), .BAUD(BAUD), .DW(8)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .par_mode (par_mode),
        .busy     (busy),
        .txd      (txd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] b, input logic [1:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b; par_mode = m;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // waits for the start bit and samples the frame at mid-bit points
    task automatic rx_frame(input bit haspar, output logic [10:0] fr, output bit seen);
        int t;
        fr = '1; seen = 1'b0; t = 0;
        while (txd && t < 10 * BITC) begin @(negedge clk); t++; end
        if (!txd) begin
            seen = 1'b1;
            repeat (HALF) @(negedge clk);
            fr[0] = txd;
            for (int i = 0; i < 8; i++) begin
                repeat (BITC) @(negedge clk);
                fr[1 + i] = txd;
            end
            if (haspar) begin
                repeat (BITC) @(negedge clk);
                fr[9] = txd;
            end
            repeat (BITC) @(negedge clk);
            fr[10] = txd;
        end
    endtask

    function automatic logic [10:0] exp_frame(input logic [7:0] b, input logic [1:0] m);
        logic p;
        p = (m == 2'b10) ? ~(^b) : (^b);
        if (m == 2'b01 || m == 2'b10) return {1'b1, p, b, 1'b0};
        return {1'b1, 1'b1, b, 1'b0};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [10:0] fr;
        bit seen;
        int n;
        bit low_seen;

        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (6 * BITC) @(negedge clk);
        // R1 reset state
        check(txd === 1'b1, "R1 idle line", txd, 1);
        check(busy === 1'b0, "R1 idle busy", busy, 0);

        // R3 fixed pattern 0x41 without parity
        do_write(8'h41, 2'b00);
        // R5 busy one cycle after the write
        check(busy === 1'b1, "R5 busy after write", busy, 1);
        rx_frame(1'b0, fr, seen);
        check(seen && fr == 11'b11_01000001_0, "R3 0x41 frame", fr, 11'b11_01000001_0);
        wait (!busy);

        // R8 start bit length
        do_write(8'h41, 2'b00);
        n = 0;
        while (txd && n < 10 * BITC) begin @(negedge clk); n++; end
        n = 0;
        while (!txd && n < 4 * BITC) begin @(negedge clk); n++; end
        check(n == BITC, "R8 start bit length", n, BITC);
        wait (!busy);

        // R6 write while busy ignored
        do_write(8'h41, 2'b00);
        repeat (2) @(negedge clk);
        do_write(8'hFF, 2'b01);
        rx_frame(1'b0, fr, seen);
        check(seen && fr == exp_frame(8'h41, 2'b00), "R6 byte in flight kept", fr, exp_frame(8'h41, 2'b00));
        wait (!busy);
        low_seen = 1'b0;
        repeat (30 * BITC) begin @(negedge clk); if (!txd) low_seen = 1'b1; end
        check(!low_seen, "R6 no extra frame", low_seen, 0);

        // R2 R4 R5 R7 sweep over every byte and parity mode, back to back
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 256; b++) begin
                logic [10:0] ef;
                bit busy_mid, busy_end, line_end;
                ef = exp_frame(8'(b), 2'(m));
                do_write(8'(b), 2'(m));
                rx_frame(m == 1 || m == 2, fr, seen);
                busy_mid = busy;
                repeat (HALF + 8) @(negedge clk);
                busy_end = busy;
                line_end = txd;
                check(seen && fr == ef, "R2 R4 R7 frame", fr, ef);
                check(busy_mid && !busy_end && line_end, "R5 busy span",
                      {busy_mid, busy_end, line_end}, 3'b101);
            end
        end

        // R9 reset in mid frame
        do_write(8'hA5, 2'b00);
        n = 0;
        while (txd && n < 10 * BITC) begin @(negedge clk); n++; end
        repeat (3 * BITC) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (6 * BITC) @(negedge clk);
        check(txd === 1'b1 && busy === 1'b0, "R9 reset mid frame", {txd, busy}, 2'b10);
        do_write(8'h3C, 2'b01);
        rx_frame(1'b1, fr, seen);
        check(seen && fr == exp_frame(8'h3C, 2'b01), "R9 frame after reset", fr, exp_frame(8'h3C, 2'b01));
        wait (!busy);
        repeat (BITC) @(negedge clk);
        check(txd === 1'b1, "R1 idle after frame", txd, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule